// File: doc/BRIEF.md
# PCS Channel Status and Control Register Bank

This block is the per-channel register bank of an Ethernet physical coding sublayer. A host reaches it over a simple 32-bit read/write bus. Every access is word-aligned, and address bits 1:0 are ignored. Each register is 16 bits wide and sits in its own 32-bit word. The bank applies a fixed access rule to each register:

- plain read/write configuration
- read-only status
- write-only key
- a clear-on-read saturating counter
- latch-high event bits
- latch-low event bits
- self-clearing command bits
- eight read/write tag-protocol-identifier values

The hardware side feeds status levels, event pulses and a count-increment pulse into the bank. It receives the configuration values and one-cycle command pulses from the bank.

A small state machine runs the bus. In state `ST_IDLE` the bank raises `bus_ready` and accepts a request. Transition *accept-write* goes from `ST_IDLE` to `ST_WACK`. Transition *accept-read* goes from `ST_IDLE` to `ST_RACK`. In either acknowledge state `bus_ack` is high for exactly one cycle. Transition *complete* then returns the machine to `ST_IDLE`. In `ST_RACK`, `bus_rvalid` is also high and `bus_rdata` holds the word captured at the accept edge. Any side effect of a read takes place at that same accept edge.

Register words, by byte address:

| Address | Register |
|---|---|
| 0x00 | control |
| 0x04 | command |
| 0x08 | status |
| 0x0C | latch-high events |
| 0x10 | latch-low events |
| 0x14 | counter |
| 0x18 | key |
| 0x20 + 4·n | identifier n, for n = 0..7 |

All other words are reserved.

Top module: `pcs_chan_regbank`

## Requirements
- R1: A request is accepted at a rising edge where `bus_req` and `bus_ready` are both high. In the next cycle `bus_ack` is high and `bus_ready` is low for exactly one cycle. For a read, `bus_rvalid` is high in that same cycle.
- R2: Read data bits 31:16 are always zero, and write data bits 31:16 are ignored.
- R3: After reset, every register reads zero, with two exceptions: the latch-low register (0x10) reads 0xFFFF and each identifier register reads 0x8100. `cfg_ctrl` is 0 and every `tpid_cfg` slice is 0x8100.
- R4: The control word (0x00) and identifier word n (0x20+4n) read back the low 16 bits last written. They drive `cfg_ctrl` and `tpid_cfg[16n+15:16n]` from the cycle after the accept.
- R5: The status word (0x08) reads `status_in` and ignores writes. The key word (0x18) drives `key_out` with the written value and reads as zero.
- R6: A pulse on bit i of `evt_hi` sets bit i of word 0x0C, and the bit stays set until that word is read. The read returns the bit as 1 and then clears it. If an event arrives in the cycle of the clearing read, the read returns the old value and the bit stays set afterwards.
- R7: A pulse on bit i of `evt_lo` clears bit i of word 0x10, and the bit stays at 0 until that word is read. The read returns the 0 and then restores the bit to 1, unless an event arrives in the same cycle.
- R8: Each cycle with `cnt_inc` high adds one to word 0x14. The counter saturates at 0xFFFF and does not wrap. A read returns the count and then zeroes it. An increment in the cycle of the read is kept, so the next read returns 1.
- R9: Writing 1 to bit i of word 0x04 raises `cmd_pulse[i]` for exactly the one cycle after the accept. Word 0x04 reads as zero.
- R10: Reserved words (0x1C, and 0x40 and above) read as zero. Writes to them change no output and no other register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address, word-aligned |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Bank can accept a request |
| bus_ack | output | 1 | Access completed (one cycle) |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| status_in | input | 16 | Status levels shown in word 0x08 |
| evt_hi | input | 16 | Event pulses for the latch-high word |
| evt_lo | input | 16 | Event pulses for the latch-low word |
| cnt_inc | input | 1 | Counter increment pulse |
| cfg_ctrl | output | 16 | Control configuration |
| key_out | output | 16 | Write-only key value |
| cmd_pulse | output | 4 | Self-clearing command pulses |
| tpid_cfg | output | 128 | Eight 16-bit identifier values, n at bits 16n+15:16n |

## Verification
Each access type is exercised with directed patterns:

- **Full 32-bit writes.** The upper half is set, which separates the masking of bits 31:16 from plain storage.
- **Events outside a read and events in the clearing read's own cycle.** These separate a latch that merely holds an event from one that drops an event arriving during the clear.
- **Counter increments.** Isolated pulses show the count and the clear; an increment during a read shows that it is kept. A held increment run past 65535 separates saturation from wrap-around.
- **Writes to the read-only word and to reserved words.** Each is followed by reads and output checks, which show whether any neighbouring register was disturbed.

// File: rtl/pcs_rb_pkg.sv
package pcs_rb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WACK = 2'd1,
        ST_RACK = 2'd2
    } bus_state_e;

    localparam int unsigned IDX_CTRL  = 0;
    localparam int unsigned IDX_CMD   = 1;
    localparam int unsigned IDX_STAT  = 2;
    localparam int unsigned IDX_LATHI = 3;
    localparam int unsigned IDX_LATLO = 4;
    localparam int unsigned IDX_CNT   = 5;
    localparam int unsigned IDX_KEY   = 6;
    localparam int unsigned IDX_TPID0 = 8;
endpackage

// File: rtl/pcs_rb_bus_fsm.sv
module pcs_rb_bus_fsm
    import pcs_rb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic we,
    output logic ready,
    output logic acc_wr,
    output logic acc_rd,
    output logic ack,
    output logic rvalid
);
    bus_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req) state_d = we ? ST_WACK : ST_RACK;
            ST_WACK: state_d = ST_IDLE;
            ST_RACK: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ready  = 1'b0;
        ack    = 1'b0;
        rvalid = 1'b0;
        acc_wr = 1'b0;
        acc_rd = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                ready  = 1'b1;
                acc_wr = req && we;
                acc_rd = req && !we;
            end
            ST_WACK: ack = 1'b1;
            ST_RACK: begin
                ack    = 1'b1;
                rvalid = 1'b1;
            end
            default: ;
        endcase
    end

    assert_accept_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> (ack && !ready));
    assert_ack_once_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (!ack && ready));
endmodule

// File: rtl/pcs_rb_event_latch.sv
module pcs_rb_event_latch #(
    parameter int unsigned W        = 16,
    parameter bit          IDLE_ONE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic         rd_clr,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] IDLE_VEC = IDLE_ONE ? {W{1'b1}} : {W{1'b0}};

    logic [W-1:0] act_q;
    logic [W-1:0] act_d;

    assign act_d = (rd_clr ? '0 : act_q) | ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_d;
    end

    assign q = act_q ^ IDLE_VEC;

    // R6 and R7: an event is never lost, even during a clearing read
    assert_evt_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev) |=> ((q ^ IDLE_VEC) & $past(ev)) == $past(ev));
    assert_quiet_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && ev == '0) |=> $stable(q));
endmodule

// File: rtl/pcs_rb_sat_counter.sv
module pcs_rb_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         rd_clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt_q <= '0;
        else if (rd_clr)      cnt_q <= {{(W-1){1'b0}}, inc};
        else if (inc && cnt_q != MAXV) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt = cnt_q;

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == MAXV && !rd_clr) |=> (cnt == MAXV));
    assert_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !inc) |=> (cnt == '0));
endmodule

// File: rtl/pcs_chan_regbank.sv
module pcs_chan_regbank
    import pcs_rb_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned BUS_W    = 32,
    parameter int unsigned REG_W    = 16,
    parameter int unsigned CMD_W    = 4,
    parameter int unsigned N_TPID   = 8,
    parameter logic [15:0] TPID_RST = 16'h8100
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [BUS_W-1:0]        bus_wdata,
    output logic                    bus_ready,
    output logic                    bus_ack,
    output logic                    bus_rvalid,
    output logic [BUS_W-1:0]        bus_rdata,
    input  logic [REG_W-1:0]        status_in,
    input  logic [REG_W-1:0]        evt_hi,
    input  logic [REG_W-1:0]        evt_lo,
    input  logic                    cnt_inc,
    output logic [REG_W-1:0]        cfg_ctrl,
    output logic [REG_W-1:0]        key_out,
    output logic [CMD_W-1:0]        cmd_pulse,
    output logic [N_TPID*REG_W-1:0] tpid_cfg
);
    localparam int unsigned IDX_W  = ADDR_W - 2;
    localparam int unsigned TSEL_W = (N_TPID > 1) ? $clog2(N_TPID) : 1;

    logic             acc_wr, acc_rd;
    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] wlo;
    logic [IDX_W-1:0] tpid_off;
    logic             tpid_hit;

    assign idx      = bus_addr[ADDR_W-1:2];
    assign wlo      = bus_wdata[REG_W-1:0];
    assign tpid_off = idx - IDX_W'(IDX_TPID0);
    assign tpid_hit = (idx >= IDX_W'(IDX_TPID0)) &&
                      (idx <  IDX_W'(IDX_TPID0 + N_TPID));

    pcs_rb_bus_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (bus_req),
        .we     (bus_we),
        .ready  (bus_ready),
        .acc_wr (acc_wr),
        .acc_rd (acc_rd),
        .ack    (bus_ack),
        .rvalid (bus_rvalid)
    );

    // Plain read/write, write-only and self-clearing registers
    logic [REG_W-1:0] ctrl_q, key_q;
    logic [CMD_W-1:0] cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            key_q  <= '0;
            cmd_q  <= '0;
        end else begin
            cmd_q <= '0;
            if (acc_wr) begin
                if (idx == IDX_W'(IDX_CTRL)) ctrl_q <= wlo;
                if (idx == IDX_W'(IDX_KEY))  key_q  <= wlo;
                if (idx == IDX_W'(IDX_CMD))  cmd_q  <= wlo[CMD_W-1:0];
            end
        end
    end

    assign cfg_ctrl  = ctrl_q;
    assign key_out   = key_q;
    assign cmd_pulse = cmd_q;

    // Identifier registers
    logic [REG_W-1:0] tpid_q [N_TPID];

    for (genvar g = 0; g < N_TPID; g++) begin : g_tpid
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tpid_q[g] <= TPID_RST;
            else if (acc_wr && tpid_hit && tpid_off == IDX_W'(g)) tpid_q[g] <= wlo;
        end
        assign tpid_cfg[g*REG_W +: REG_W] = tpid_q[g];
    end

    // Event latches and counter
    logic [REG_W-1:0] lathi, latlo, cnt;
    logic             clr_hi, clr_lo, clr_cnt;

    assign clr_hi  = acc_rd && (idx == IDX_W'(IDX_LATHI));
    assign clr_lo  = acc_rd && (idx == IDX_W'(IDX_LATLO));
    assign clr_cnt = acc_rd && (idx == IDX_W'(IDX_CNT));

    pcs_rb_event_latch #(.W(REG_W), .IDLE_ONE(1'b0)) u_lathi (
        .clk(clk), .rst_n(rst_n), .ev(evt_hi), .rd_clr(clr_hi), .q(lathi)
    );

    pcs_rb_event_latch #(.W(REG_W), .IDLE_ONE(1'b1)) u_latlo (
        .clk(clk), .rst_n(rst_n), .ev(evt_lo), .rd_clr(clr_lo), .q(latlo)
    );

    pcs_rb_sat_counter #(.W(REG_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc(cnt_inc), .rd_clr(clr_cnt), .cnt(cnt)
    );

    // Read path
    logic [REG_W-1:0] rd_mux;
    logic [BUS_W-1:0] rdata_q;

    always_comb begin
        rd_mux = '0;
        if (idx == IDX_W'(IDX_CTRL))       rd_mux = ctrl_q;
        else if (idx == IDX_W'(IDX_STAT))  rd_mux = status_in;
        else if (idx == IDX_W'(IDX_LATHI)) rd_mux = lathi;
        else if (idx == IDX_W'(IDX_LATLO)) rd_mux = latlo;
        else if (idx == IDX_W'(IDX_CNT))   rd_mux = cnt;
        else if (tpid_hit)                 rd_mux = tpid_q[tpid_off[TSEL_W-1:0]];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (acc_rd) rdata_q <= {{(BUS_W-REG_W){1'b0}}, rd_mux};
    end

    assign bus_rdata = rdata_q;

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[BUS_W-1:REG_W] == '0));
    assert_cmd_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_pulse) |=> (cmd_pulse == '0));
    assert_ctrl_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr |=> $stable(cfg_ctrl));
    assert_tpid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_wr && tpid_hit) |=> $stable(tpid_cfg));
endmodule

// File: tb/pcs_chan_regbank_tb.sv
module pcs_chan_regbank_tb;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_req = 1'b0, bus_we = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_ready, bus_ack, bus_rvalid;
    logic [31:0]  bus_rdata;
    logic [15:0]  status_in = '0, evt_hi = '0, evt_lo = '0;
    logic         cnt_inc = 1'b0;
    logic [15:0]  cfg_ctrl, key_out;
    logic [3:0]   cmd_pulse;
    logic [127:0] tpid_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcs_chan_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_ack(bus_ack), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
        .status_in(status_in), .evt_hi(evt_hi), .evt_lo(evt_lo),
        .cnt_inc(cnt_inc), .cfg_ctrl(cfg_ctrl), .key_out(key_out),
        .cmd_pulse(cmd_pulse), .tpid_cfg(tpid_cfg)
    );

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        @(posedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        chk("R1 ack/rvalid/ready", {bus_ack, bus_rvalid, bus_ready}, 3'b110);
        d = bus_rdata;
        bus_req = 1'b0;
        @(posedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        @(negedge clk);
        chk("R3 ready after reset", bus_ready, 1'b1);
        chk("R3 cfg_ctrl", cfg_ctrl, 16'h0);
        for (int i = 0; i < 8; i++) chk("R3 tpid_cfg", tpid_cfg[i*16 +: 16], 16'h8100);
        bus_read(8'h00, d); chk("R3 ctrl word", d, 32'h0);
        bus_read(8'h10, d); chk("R3 latch-low word", d, 32'h0000_FFFF);
        bus_read(8'h0C, d); chk("R3 latch-high word", d, 32'h0);
        bus_read(8'h14, d); chk("R3 counter word", d, 32'h0);
        bus_read(8'h3C, d); chk("R3 last tpid word", d, 32'h0000_8100);
        @(negedge clk);
        chk("R1 ready back", bus_ready, 1'b1);
    endtask

    task automatic t_rw_upper();
        logic [31:0] d;
        bus_write(8'h00, 32'hFFFF_1234);
        bus_read(8'h00, d);
        chk("R2 upper masked", d, 32'h0000_1234);
        chk("R4 cfg_ctrl", cfg_ctrl, 16'h1234);
        bus_write(8'h34, 32'hABCD_88A8);
        bus_read(8'h34, d);
        chk("R4 tpid5 read", d, 32'h0000_88A8);
        chk("R4 tpid5 out", tpid_cfg[5*16 +: 16], 16'h88A8);
        chk("R4 tpid6 untouched", tpid_cfg[6*16 +: 16], 16'h8100);
    endtask

    task automatic t_ro_wo();
        logic [31:0] d;
        status_in = 16'hA5C3;
        bus_read(8'h08, d); chk("R5 status read", d, 32'h0000_A5C3);
        bus_write(8'h08, 32'h0000_1234);
        bus_read(8'h08, d); chk("R5 status ignores write", d, 32'h0000_A5C3);
        chk("R5 status write leaves ctrl", cfg_ctrl, 16'h1234);
        bus_write(8'h18, 32'h0000_BEEF);
        chk("R5 key out", key_out, 16'hBEEF);
        bus_read(8'h18, d); chk("R5 key reads zero", d, 32'h0);
    endtask

    task automatic t_latch_hi();
        logic [31:0] d;
        @(negedge clk); evt_hi = 16'h0011;
        @(negedge clk); evt_hi = 16'h0;
        repeat (3) @(negedge clk);
        bus_read(8'h0C, d); chk("R6 latched", d, 32'h0000_0011);
        bus_read(8'h0C, d); chk("R6 cleared by read", d, 32'h0);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h0C; evt_hi = 16'h0008;
        @(posedge clk);
        @(negedge clk);
        evt_hi = 16'h0; d = bus_rdata; bus_req = 1'b0;
        chk("R6 read during event returns old", d, 32'h0);
        @(posedge clk);
        bus_read(8'h0C, d); chk("R6 event in read cycle kept", d, 32'h0000_0008);
        bus_read(8'h0C, d); chk("R6 cleared again", d, 32'h0);
    endtask

    task automatic t_latch_lo();
        logic [31:0] d;
        @(negedge clk); evt_lo = 16'h0004;
        @(negedge clk); evt_lo = 16'h0;
        bus_read(8'h10, d); chk("R7 latched low", d, 32'h0000_FFFB);
        bus_read(8'h10, d); chk("R7 restored by read", d, 32'h0000_FFFF);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h10; evt_lo = 16'h8000;
        @(posedge clk);
        @(negedge clk);
        evt_lo = 16'h0; bus_req = 1'b0;
        @(posedge clk);
        bus_read(8'h10, d); chk("R7 event in read cycle kept", d, 32'h0000_7FFF);
    endtask

    task automatic t_counter();
        logic [31:0] d;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); cnt_inc = 1'b1;
            @(negedge clk); cnt_inc = 1'b0;
        end
        bus_read(8'h14, d); chk("R8 count five", d, 32'd5);
        @(negedge clk); cnt_inc = 1'b1;
        @(negedge clk); cnt_inc = 1'b0;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h14; cnt_inc = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cnt_inc = 1'b0; d = bus_rdata; bus_req = 1'b0;
        chk("R8 read returns prior", d, 32'd1);
        @(posedge clk);
        bus_read(8'h14, d); chk("R8 inc in read cycle kept", d, 32'd1);
        @(negedge clk); cnt_inc = 1'b1;
        repeat (70000) @(negedge clk);
        cnt_inc = 1'b0;
        bus_read(8'h14, d); chk("R8 saturates", d, 32'h0000_FFFF);
        bus_read(8'h14, d); chk("R8 zero after read", d, 32'h0);
    endtask

    task automatic t_cmd();
        logic [31:0] d;
        @(negedge clk);
        chk("R9 idle pulses", cmd_pulse, 4'h0);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_0005;
        @(posedge clk);
        @(negedge clk);
        chk("R9 pulse after accept", cmd_pulse, 4'h5);
        chk("R1 write ack", {bus_ack, bus_rvalid, bus_ready}, 3'b100);
        bus_req = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R9 pulse self-clears", cmd_pulse, 4'h0);
        bus_read(8'h04, d); chk("R9 reads zero", d, 32'h0);
    endtask

    task automatic t_reserved();
        logic [31:0] d;
        bus_write(8'h1C, 32'hFFFF_FFFF);
        bus_write(8'h40, 32'hFFFF_FFFF);
        bus_read(8'h1C, d); chk("R10 reserved 0x1C", d, 32'h0);
        bus_read(8'h40, d); chk("R10 reserved 0x40", d, 32'h0);
        chk("R10 ctrl unchanged", cfg_ctrl, 16'h1234);
        chk("R10 key unchanged", key_out, 16'hBEEF);
        chk("R10 tpid0 unchanged", tpid_cfg[15:0], 16'h8100);
        chk("R10 tpid5 unchanged", tpid_cfg[5*16 +: 16], 16'h88A8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_rw_upper();
        t_ro_wo();
        t_latch_hi();
        t_latch_lo();
        t_counter();
        t_cmd();
        t_reserved();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule